// File: doc/BRIEF.md
# Raster-Operation Rectangle Copy Engine

This block copies a rectangle of pixels from one surface in memory to another and merges each source pixel with the pixel already at the destination. The merge is an 8-bit truth table that the command supplies, so one engine performs plain copies, logic combines, inversions and fills. A command is eight 32-bit words, presented all at once on a valid/ready input. The engine then works pixel by pixel through a single memory port: it reads the source word, reads the destination word, and writes the merged result with byte enables. A one-cycle done pulse follows the last write.

Each surface is either linear or tiled in X-major order. A tile is 4096 bytes: 512 bytes wide and 8 rows high. Pixels are 1, 2 or 4 bytes. For 4-byte pixels the colour lanes and the alpha lane can each be written or left alone. No pattern is fetched, so the pattern input of the truth table is always 0.

Top module: `blit_rop3_copy`

## Requirements
- R1: Each result bit is the truth-table bit at index {pattern, source, destination}, where pattern is always 0. So 0xCC copies the source, 0xAA keeps the destination, 0x88 is AND, 0xEE is OR, 0x66 is XOR, 0x55 inverts the destination, 0x00 clears and 0xFF sets.
- R2: The command is eight words, with word k in cmd_i[32k+31:32k]. Word 0 holds the flags. Word 1 holds depth[25:24], the truth table[23:16] and the destination pitch[15:0]. Words 2 and 3 are the destination's first and exclusive second corner. Word 4 is the destination base. Word 5 is the source's first corner. Word 6 holds the source pitch[15:0]. Word 7 is the source base. Every corner is packed as y[31:16] and x[15:0].
- R3: Depth code 0 selects 1-byte pixels, 1 selects 2-byte pixels and 3 selects 4-byte pixels. Code 2 is rejected: the engine makes no memory access and raises done.
- R4: If the second corner's x is not greater than the first corner's x, or its y is not greater than the first corner's y, the engine writes nothing and raises done in the first cycle after acceptance.
- R5: Pixels are visited row by row from the first corner. A linear address is base + y*pitch + x*bytes. Byte enables cover only the pixel's own lanes, at address bits [1:0] of the destination.
- R6: For 4-byte pixels, word 0 bit 2 enables bytes 0 to 2 (colour) and bit 3 enables byte 3 (alpha). A disabled lane keeps its old value.
- R7: Word 0 bit 0 marks the destination as tiled and bit 1 marks the source as tiled. For a tiled surface, pitch is counted in 4-byte units. Its address is base + (y/8)*pitch_bytes*8 + (xb/512)*4096 + (y%8)*512 + xb%512, where xb is x times the pixel size.
- R8: A tiled surface whose base is not a multiple of 4096 is rejected: the engine makes no memory access and raises done.
- R9: cmd_ready_o is high only when the engine is idle. It falls in the cycle after a command is accepted and stays low until done_o has been high for one cycle.
- R10: Read data arrives one cycle after the read request. Each pixel takes a source read, a destination read and a write, in that order. From acceptance to done takes 3*pixels+1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command present |
| cmd_ready_o | output | 1 | Engine idle, command taken when valid is also high |
| cmd_i | input | 256 | Eight packed command words |
| mem_req_o | output | 1 | Memory access this cycle |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | AW | Byte address; the word is selected by bits above 1 |
| mem_be_o | output | 4 | Byte lane write enables |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, one cycle after the request |
| done_o | output | 1 | One-cycle pulse when the command is finished |

## Verification
The bench builds the block with its default 32-bit address. Its memory model holds 16 KB, which is enough for two tile columns and two tile rows of a tiled destination. This lets one rectangle cross both a 512-byte tile column edge and an 8-row tile row edge. Source and destination lanes are chosen to differ, so the lane shift between them is exercised. For every pixel size, the complete memory image is compared against a reference model kept in the bench.

// File: rtl/blit_pkg.sv
package blit_pkg;
  localparam int WORD_W    = 32;
  localparam int CMD_WORDS = 8;
  localparam int COORD_W   = 16;
  localparam int LANES     = WORD_W / 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RSRC,
    ST_RDST,
    ST_WR,
    ST_DONE
  } blit_st_e;

  typedef struct packed {
    logic [COORD_W-1:0] y;
    logic [COORD_W-1:0] x;
  } point_t;
endpackage

// File: rtl/blit_addr_gen.sv
module blit_addr_gen #(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int TILE_W_LOG2 = 9,
  parameter int TILE_H_LOG2 = 3
) (
  input  logic [AW-1:0] base_i,
  input  logic [CW-1:0] pitch_i,
  input  logic          tiled_i,
  input  logic [1:0]    bpp_log2_i,
  input  logic [CW-1:0] x_i,
  input  logic [CW-1:0] y_i,
  output logic [AW-1:0] addr_o
);
  localparam int TILE_LOG2 = TILE_W_LOG2 + TILE_H_LOG2;

  logic [AW-1:0] xb, yy, pitch_b, lin_off, til_off;

  always_comb begin
    xb      = AW'(x_i) << bpp_log2_i;
    yy      = AW'(y_i);
    pitch_b = tiled_i ? (AW'(pitch_i) << 2) : AW'(pitch_i);
    lin_off = yy * pitch_b + xb;
    // tile row stride = pitch * tile height; tiles 4 KB apart within a row
    til_off = (yy >> TILE_H_LOG2) * (pitch_b << TILE_H_LOG2)
            + ((xb >> TILE_W_LOG2) << TILE_LOG2)
            + ((yy & AW'((1 << TILE_H_LOG2) - 1)) << TILE_W_LOG2)
            + (xb & AW'((1 << TILE_W_LOG2) - 1));
    addr_o  = base_i + (tiled_i ? til_off : lin_off);
  end
endmodule

// File: rtl/blit_rop_unit.sv
module blit_rop_unit #(
  parameter int W = 32
) (
  input  logic [7:0]   rop_i,
  input  logic [W-1:0] src_i,
  input  logic [W-1:0] dst_i,
  output logic [W-1:0] res_o
);
  // pattern term tied to 0: index = {1'b0, s, d}
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign res_o[i] = rop_i[{1'b0, src_i[i], dst_i[i]}];
  end
endmodule

// File: rtl/blit_rop3_copy.sv
module blit_rop3_copy
  import blit_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          cmd_valid_i,
  output logic                          cmd_ready_o,
  input  logic [CMD_WORDS*WORD_W-1:0]   cmd_i,
  output logic                          mem_req_o,
  output logic                          mem_we_o,
  output logic [AW-1:0]                 mem_addr_o,
  output logic [LANES-1:0]              mem_be_o,
  output logic [WORD_W-1:0]             mem_wdata_o,
  input  logic [WORD_W-1:0]             mem_rdata_i,
  output logic                          done_o
);
  localparam int CW = COORD_W;
  localparam int TILE_ALIGN = 12;

  logic [WORD_W-1:0] w [CMD_WORDS];
  for (genvar k = 0; k < CMD_WORDS; k++) begin : g_word
    assign w[k] = cmd_i[k*WORD_W +: WORD_W];
  end

  // command decode
  logic [1:0] depth_n, bl_n;
  logic       empty_n, bad_n;
  point_t     d1_n, d2_n;

  always_comb begin
    d1_n    = point_t'(w[2]);
    d2_n    = point_t'(w[3]);
    depth_n = w[1][25:24];
    bl_n    = (depth_n == 2'b11) ? 2'd2 : {1'b0, depth_n[0]};
    empty_n = (d2_n.x <= d1_n.x) || (d2_n.y <= d1_n.y);
    bad_n   = (depth_n == 2'b10)
           || (w[0][0] && w[4][TILE_ALIGN-1:0] != '0)
           || (w[0][1] && w[7][TILE_ALIGN-1:0] != '0);
  end

  logic unused_cmd_bits;
  assign unused_cmd_bits = ^{w[0][WORD_W-1:4], w[1][WORD_W-1:26], w[6][WORD_W-1:CW]};

  blit_st_e          st_q;
  logic [7:0]        rop_q;
  logic [1:0]        bl_q;
  logic              dtile_q, stile_q, wrgb_q, walpha_q;
  logic [CW-1:0]     dpitch_q, spitch_q, wid_q, hgt_q, cx_q, cy_q;
  logic [AW-1:0]     dbase_q, sbase_q;
  point_t            dorg_q, sorg_q;
  logic [WORD_W-1:0] srcw_q;

  wire accept   = cmd_valid_i && cmd_ready_o;
  wire last_col = (cx_q == wid_q - CW'(1));
  wire last_row = (cy_q == hgt_q - CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      rop_q    <= '0;
      bl_q     <= '0;
      dtile_q  <= 1'b0;
      stile_q  <= 1'b0;
      wrgb_q   <= 1'b0;
      walpha_q <= 1'b0;
      dpitch_q <= '0;
      spitch_q <= '0;
      wid_q    <= '0;
      hgt_q    <= '0;
      cx_q     <= '0;
      cy_q     <= '0;
      dbase_q  <= '0;
      sbase_q  <= '0;
      dorg_q   <= '0;
      sorg_q   <= '0;
      srcw_q   <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (accept) begin
          rop_q    <= w[1][23:16];
          bl_q     <= bl_n;
          dtile_q  <= w[0][0];
          stile_q  <= w[0][1];
          wrgb_q   <= w[0][2];
          walpha_q <= w[0][3];
          dpitch_q <= w[1][CW-1:0];
          spitch_q <= w[6][CW-1:0];
          dbase_q  <= AW'(w[4]);
          sbase_q  <= AW'(w[7]);
          dorg_q   <= d1_n;
          sorg_q   <= point_t'(w[5]);
          wid_q    <= d2_n.x - d1_n.x;
          hgt_q    <= d2_n.y - d1_n.y;
          cx_q     <= '0;
          cy_q     <= '0;
          st_q     <= (empty_n || bad_n) ? ST_DONE : ST_RSRC;
        end
        ST_RSRC: st_q <= ST_RDST;
        ST_RDST: begin
          srcw_q <= mem_rdata_i;
          st_q   <= ST_WR;
        end
        ST_WR: begin
          if (!last_col) begin
            cx_q <= cx_q + CW'(1);
            st_q <= ST_RSRC;
          end else begin
            cx_q <= '0;
            if (last_row) st_q <= ST_DONE;
            else begin
              cy_q <= cy_q + CW'(1);
              st_q <= ST_RSRC;
            end
          end
        end
        ST_DONE: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // addressing
  logic [CW-1:0] dx_c, dy_c, sx_c, sy_c;
  logic [AW-1:0] daddr, saddr;
  assign dx_c = dorg_q.x + cx_q;
  assign dy_c = dorg_q.y + cy_q;
  assign sx_c = sorg_q.x + cx_q;
  assign sy_c = sorg_q.y + cy_q;

  blit_addr_gen #(.AW(AW), .CW(CW)) u_dst_addr (
    .base_i(dbase_q), .pitch_i(dpitch_q), .tiled_i(dtile_q), .bpp_log2_i(bl_q),
    .x_i(dx_c), .y_i(dy_c), .addr_o(daddr)
  );
  blit_addr_gen #(.AW(AW), .CW(CW)) u_src_addr (
    .base_i(sbase_q), .pitch_i(spitch_q), .tiled_i(stile_q), .bpp_log2_i(bl_q),
    .x_i(sx_c), .y_i(sy_c), .addr_o(saddr)
  );

  // lane alignment and merge
  logic [WORD_W-1:0] src_al;
  logic [LANES-1:0]  be_pix;
  assign src_al = (srcw_q >> {saddr[1:0], 3'b000}) << {daddr[1:0], 3'b000};

  always_comb begin
    unique case (bl_q)
      2'd0:    be_pix = 4'b0001;
      2'd1:    be_pix = 4'b0011;
      default: be_pix = {walpha_q, {3{wrgb_q}}};
    endcase
  end

  blit_rop_unit #(.W(WORD_W)) u_rop (
    .rop_i(rop_q), .src_i(src_al), .dst_i(mem_rdata_i), .res_o(mem_wdata_o)
  );

  assign cmd_ready_o = (st_q == ST_IDLE);
  assign done_o      = (st_q == ST_DONE);
  assign mem_req_o   = (st_q == ST_RSRC) || (st_q == ST_RDST) || (st_q == ST_WR);
  assign mem_we_o    = (st_q == ST_WR);
  assign mem_addr_o  = (st_q == ST_RSRC) ? saddr : daddr;
  assign mem_be_o    = (st_q == ST_WR) ? (be_pix << daddr[1:0]) : '0;

  // assertions
  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_ready_drop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_ready_o) |=> !cmd_ready_o);
  p_write_spacing_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |=> !(mem_req_o && mem_we_o));
  p_read_before_write_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |-> $past(mem_req_o && !mem_we_o));
  p_byte_lane_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && bl_q == 2'd0) |-> ($countones(mem_be_o) <= 1));
  p_alpha_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && bl_q == 2'd2 && !walpha_q) |-> !mem_be_o[3]);
  p_idle_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_ready_o || done_o) |-> !mem_req_o);
endmodule

// File: tb/sim_blit_rop3_copy.sv
module sim_blit_rop3_copy;
  localparam int MEM_BYTES = 16384;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic         cmd_valid = 1'b0;
  logic         cmd_ready;
  logic [255:0] cmd = '0;
  logic         mem_req, mem_we, done;
  logic [31:0]  mem_addr, mem_wdata, mem_rdata;
  logic [3:0]   mem_be;

  blit_rop3_copy u0 (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
    .cmd_i(cmd), .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_be_o(mem_be), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .done_o(done)
  );

  logic [7:0] mem  [MEM_BYTES];
  logic [7:0] expm [MEM_BYTES];
  logic [13:0] ma;
  assign ma = mem_addr[13:0] & 14'h3FFC;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'(i * 37 + 5);
      mem_rdata <= '0;
    end else if (mem_req) begin
      if (mem_we) begin
        for (int k = 0; k < 4; k++) if (mem_be[k]) mem[int'(ma) + k] <= mem_wdata[8*k +: 8];
      end else begin
        mem_rdata <= {mem[int'(ma)+3], mem[int'(ma)+2], mem[int'(ma)+1], mem[int'(ma)]};
      end
    end
  end

  int  checks = 0, errors = 0, wr_cnt = 0;
  bit  wr_clr = 1'b0, finished = 1'b0;
  always @(posedge clk) begin
    if (wr_clr) wr_cnt <= 0;
    else if (mem_req && mem_we) wr_cnt <= wr_cnt + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [255:0] mk(input logic [31:0] w0, w1, w2, w3, w4, w5, w6, w7);
    return {w7, w6, w5, w4, w3, w2, w1, w0};
  endfunction

  function automatic logic [31:0] pt(input int x, input int y);
    return {16'(y), 16'(x)};
  endfunction

  function automatic logic [31:0] ctl(input int depth, input int rop, input int pitch);
    return {6'b0, 2'(depth), 8'(rop), 16'(pitch)};
  endfunction

  function automatic int addr_of(input int base, input int pf, input bit tl,
                                 input int bl, input int x, input int y);
    int pb, xb;
    pb = tl ? pf * 4 : pf;
    xb = x << bl;
    if (tl) return base + (y / 8) * pb * 8 + (xb / 512) * 4096 + (y % 8) * 512 + xb % 512;
    return base + y * pb + xb;
  endfunction

  task automatic ref_apply(input logic [255:0] c, output int npix);
    logic [31:0] w [8];
    int depth, bl, wd, ht, sa, da;
    bit dt, stl, rgb, alp, rej;
    logic [7:0] rop, s, d, r;
    for (int k = 0; k < 8; k++) w[k] = c[32*k +: 32];
    dt = w[0][0]; stl = w[0][1]; rgb = w[0][2]; alp = w[0][3];
    depth = int'(w[1][25:24]);
    rop = w[1][23:16];
    bl = (depth == 3) ? 2 : depth;
    wd = int'(w[3][15:0]) - int'(w[2][15:0]);
    ht = int'(w[3][31:16]) - int'(w[2][31:16]);
    rej = (wd <= 0) || (ht <= 0) || (depth == 2)
       || (dt && w[4][11:0] != 0) || (stl && w[7][11:0] != 0);
    npix = 0;
    if (rej) return;
    npix = wd * ht;
    for (int yy = 0; yy < ht; yy++)
      for (int xx = 0; xx < wd; xx++) begin
        sa = addr_of(int'(w[7]), int'(w[6][15:0]), stl, bl,
                     int'(w[5][15:0]) + xx, int'(w[5][31:16]) + yy);
        da = addr_of(int'(w[4]), int'(w[1][15:0]), dt, bl,
                     int'(w[2][15:0]) + xx, int'(w[2][31:16]) + yy);
        for (int k = 0; k < (1 << bl); k++) begin
          s = expm[(sa + k) % MEM_BYTES];
          d = expm[(da + k) % MEM_BYTES];
          for (int b = 0; b < 8; b++) r[b] = rop[{1'b0, s[b], d[b]}];
          if (bl < 2 || (k == 3 ? alp : rgb)) expm[(da + k) % MEM_BYTES] = r;
        end
      end
  endtask

  task automatic cmp_mem(input string req);
    int bad = 0, idx = 0;
    for (int i = 0; i < MEM_BYTES; i++)
      if (mem[i] !== expm[i]) begin
        if (bad == 0) idx = i;
        bad++;
      end
    chk(bad == 0, req, int'(mem[idx]), int'(expm[idx]));
  endtask

  task automatic run_blit(input logic [255:0] c, input string req);
    int npix, cyc;
    bit busy_ok;
    ref_apply(c, npix);
    @(negedge clk) wr_clr = 1'b1;
    @(negedge clk) wr_clr = 1'b0;
    cmd = c;
    cmd_valid = 1'b1;
    @(negedge clk) cmd_valid = 1'b0;
    busy_ok = !cmd_ready;
    cyc = 1;
    while (!done && cyc < 5000) begin
      @(negedge clk);
      cyc++;
      if (cmd_ready) busy_ok = 1'b0;
    end
    chk(busy_ok, "R9", int'(busy_ok), 1);
    chk(cyc == 3 * npix + 1, "R10", cyc, 3 * npix + 1);
    chk(wr_cnt == npix, req, wr_cnt, npix);
    cmp_mem(req);
    @(negedge clk);
    chk(!done && cmd_ready, "R9", int'({done, cmd_ready}), 1);
  endtask

  task automatic t_reset;
    chk(cmd_ready === 1'b1, "R9", int'(cmd_ready), 1);
    chk(done === 1'b0 && mem_req === 1'b0, "R9", int'({done, mem_req}), 0);
    cmp_mem("R9");
  endtask

  task automatic t_copy_8bit;  // R1 R2 R5
    run_blit(mk(0, ctl(0, 'hCC, 48), pt(5, 1), pt(12, 5), 'h2400,
                pt(3, 2), 40, 'h2000), "R5");
  endtask

  task automatic t_rop_table;  // R1
    int rops [6] = '{'h88, 'hEE, 'h55, 'h00, 'hFF, 'hAA};
    foreach (rops[i])
      run_blit(mk(0, ctl(0, rops[i], 32), pt(1, 1), pt(6, 4), 'h3100,
                  pt(0, 0), 32, 'h3000), "R1");
  endtask

  task automatic t_565_xor;  // R3
    run_blit(mk(0, ctl(1, 'h66, 64), pt(2, 3), pt(8, 6), 'h2C00,
                pt(1, 1), 64, 'h2800), "R3");
  endtask

  task automatic t_32bit_lanes;  // R6
    run_blit(mk(4, ctl(3, 'hCC, 64), pt(2, 1), pt(6, 4), 'h2400,
                pt(1, 0), 64, 'h2000), "R6");
    run_blit(mk(8, ctl(3, 'h66, 64), pt(2, 1), pt(6, 4), 'h2400,
                pt(1, 0), 64, 'h2000), "R6");
    run_blit(mk(0, ctl(3, 'hFF, 64), pt(2, 1), pt(6, 4), 'h2400,
                pt(1, 0), 64, 'h2000), "R6");
  endtask

  task automatic t_empty;  // R4
    run_blit(mk(0, ctl(0, 'hFF, 32), pt(5, 5), pt(5, 9), 'h3100,
                pt(0, 0), 32, 'h3000), "R4");
    run_blit(mk(0, ctl(0, 'hFF, 32), pt(5, 5), pt(9, 3), 'h3100,
                pt(0, 0), 32, 'h3000), "R4");
  endtask

  task automatic t_bad_depth;  // R3
    run_blit(mk(0, ctl(2, 'hFF, 32), pt(0, 0), pt(4, 4), 'h3100,
                pt(0, 0), 32, 'h3000), "R3");
  endtask

  task automatic t_tiled_dst;  // R7
    run_blit(mk(13, ctl(3, 'hCC, 256), pt(120, 6), pt(136, 10), 0,
                pt(0, 0), 128, 10240), "R7");
  endtask

  task automatic t_tiled_src;  // R7
    run_blit(mk(2, ctl(0, 'hCC, 64), pt(0, 0), pt(11, 7), 13312,
                pt(10, 5), 128, 0), "R7");
  endtask

  task automatic t_misaligned;  // R8
    run_blit(mk(1, ctl(0, 'hFF, 64), pt(0, 0), pt(4, 2), 'h100,
                pt(0, 0), 64, 'h3000), "R8");
    run_blit(mk(2, ctl(0, 'hFF, 64), pt(0, 0), pt(4, 2), 'h3000,
                pt(0, 0), 64, 'h40), "R8");
  endtask

  initial begin
    for (int i = 0; i < MEM_BYTES; i++) expm[i] = 8'(i * 37 + 5);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_copy_8bit();
    t_rop_table();
    t_565_xor();
    t_32bit_lanes();
    t_empty();
    t_bad_depth();
    t_tiled_dst();
    t_tiled_src();
    t_misaligned();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL R9 watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule